// File: doc/BRIEF.md
# Daisy-Chained Serial Control Port

This block is the serial target for one channel in a chain of channels that share one serial clock and one chip select. The host's data line enters the first channel, and each channel hands the incoming stream to the next channel through a pass-through output. Every access opens with a control byte. That byte holds a broadcast flag, a read flag, a register-or-RAM select and a channel identifier. An address byte follows. The access then closes with one data byte for an 8-bit register or two data bytes, high byte first, for a 16-bit RAM word. The host releases chip select after every byte.

As the control byte passes through, each channel lowers the identifier by one. The host therefore addresses channel k by sending identifier k, and each channel only has to recognise zero. The channel that receives zero acts on the access. On a broadcast write, every channel acts. Register reads return data in the same access. RAM reads go through a one-word buffer: the word returned by a RAM read is the one fetched for the previous RAM read to that channel.

The serial pins are synchronised into the system clock, and all edges are detected there. Reads and writes reach the channel's own storage through a plain address, write-data and strobe interface.

Top module: `spi_chain_port`

## Requirements
- R1: Control byte, sent MSB first: bit 7 broadcast, bit 6 read (1) or write (0), bit 5 RAM (1) or register (0), bit 4 unused. Bits 3..0 hold the identifier with its LSB in bit 3 and its MSB in bit 0, so the identifier goes out LSB first. A channel acts when the received identifier is zero, or when the broadcast bit is set on a write.
- R2: The pass-through output repeats the data input. During the four identifier bits of a control byte it carries the identifier minus one (modulo 16), still LSB first. The three flag bits and all address and data bytes pass unchanged.
- R3: An accepted register write is three bytes: control, address, data. It gives exactly one single-cycle register strobe, with the address on `mem_addr` and the data in `wr_data[7:0]`.
- R4: An accepted RAM write is four bytes: control, address, data high, data low. It gives exactly one single-cycle RAM strobe carrying the 16-bit word.
- R5: An accepted register read returns, in its data byte, the register value fetched at the address just sent. The value is shifted out MSB first, changes after falling SCLK edges, and is valid at each rising edge.
- R6: An accepted RAM read returns the contents of the channel's read buffer, high byte first. The buffer is then reloaded from the RAM at the new address. The buffer is zero after reset.
- R7: `spi_sdo_oe` is high only while chip select is low during the data bytes of an accepted read. No two channels ever enable at once.
- R8: A broadcast read is ignored by every channel. No channel drives SDO, and no read buffer changes.
- R9: If chip select rises after 1 to 7 bits, those bits are discarded and the access keeps its position. The next complete byte takes the place of the discarded one.
- R10: A channel that does not accept an access gives no write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock (idle low) |
| spi_cs_n | input | 1 | Active-low chip select, released after each byte |
| spi_sdi | input | 1 | Serial data in |
| spi_sdo | output | 1 | Serial read data (valid when enabled) |
| spi_sdo_oe | output | 1 | Output enable for the shared SDO line |
| spi_sdi_thru | output | 1 | Data stream to the next channel, identifier decremented |
| mem_addr | output | 8 | Address of the current access |
| wr_data | output | 16 | Write data (register data in low byte) |
| reg_we | output | 1 | Register write strobe |
| ram_we | output | 1 | RAM write strobe |
| reg_rdata | input | 8 | Register value at `mem_addr` |
| ram_rdata | input | 16 | RAM word at `mem_addr` |

## Verification
The bench builds a two-channel chain and targets the serial decrement at identifiers 0, 1, 5 and 8. Those values exercise a wrap to 15, a borrow that stops at once, and a borrow that ripples across three bits; a broken borrow chain would steer accesses to the wrong channel. It checks the one-behind RAM read result, including a broadcast read placed between two reads. A design that refreshed the buffer on a read it should ignore, or that returned fresh data, would give the wrong word. Partial bytes are placed before a control byte and in the data slot. A design that kept the stray bits, or restarted the access, would write a wrong value or none.

// File: rtl/spi_chain_pkg.sv
`timescale 1ns/1ps
package spi_chain_pkg;
    localparam int BYTE_W = 8;
    localparam int CID_W  = 4;

    typedef enum logic [1:0] {
        PH_CTRL = 2'd0,
        PH_ADDR = 2'd1,
        PH_DAT0 = 2'd2,
        PH_DAT1 = 2'd3
    } phase_e;

    // control byte as received, MSB first on the wire
    typedef struct packed {
        logic             bcast;
        logic             rd;
        logic             ram;
        logic             spare;
        logic [CID_W-1:0] cid_rev;   // identifier, LSB in the top position
    } ctl_t;
endpackage

// File: rtl/spi_chain_sync.sv
`timescale 1ns/1ps
module spi_chain_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] dout_prev
);
    logic [W-1:0] chain_q [STAGES+1];
    logic [W-1:0] chain_d [STAGES+1];

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i <= STAGES; i++) chain_d[i] = chain_q[i-1];
    end

    genvar g;
    generate
        for (g = 0; g <= STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= RST_VAL;
                else        chain_q[g] <= chain_d[g];
            end
        end
    endgenerate

    assign dout      = chain_q[STAGES-1];
    assign dout_prev = chain_q[STAGES];
endmodule

// File: rtl/spi_chain_fwd.sv
`timescale 1ns/1ps
module spi_chain_fwd (
    input  logic clk,
    input  logic rst_n,
    input  logic sdi_raw,
    input  logic sdi_s,
    input  logic rise,
    input  logic in_cid,
    output logic sdi_thru
);
    logic borrow_d, borrow_q;

    // serial subtract-one, LSB first: out = in ^ borrow, borrow &= ~in
    always_comb begin
        if (!in_cid)   borrow_d = 1'b1;
        else if (rise) borrow_d = borrow_q & ~sdi_s;
        else           borrow_d = borrow_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) borrow_q <= 1'b1;
        else        borrow_q <= borrow_d;
    end

    assign sdi_thru = in_cid ? (sdi_raw ^ borrow_q) : sdi_raw;
endmodule

// File: rtl/spi_chain_port.sv
`timescale 1ns/1ps
module spi_chain_port
    import spi_chain_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_sclk,
    input  logic        spi_cs_n,
    input  logic        spi_sdi,
    output logic        spi_sdo,
    output logic        spi_sdo_oe,
    output logic        spi_sdi_thru,
    output logic [7:0]  mem_addr,
    output logic [15:0] wr_data,
    output logic        reg_we,
    output logic        ram_we,
    input  logic [7:0]  reg_rdata,
    input  logic [15:0] ram_rdata
);
    localparam int CNT_W     = $clog2(BYTE_W + 1);
    localparam int FLAG_BITS = BYTE_W - CID_W;
    localparam int WORD_W    = 2 * BYTE_W;

    typedef struct packed {
        phase_e              phase;
        phase_e              phase_nx;
        logic [CNT_W-1:0]    bits;
        logic [BYTE_W-2:0]   sh;
        logic                bcast;
        logic                rd;
        logic                ram;
        logic                acc;
        logic [BYTE_W-1:0]   addr;
        logic [BYTE_W-1:0]   hi;
        logic [WORD_W-1:0]   tx;
        logic [WORD_W-1:0]   rbuf;
        logic                fetch;
        logic                reg_we;
        logic                ram_we;
        logic [WORD_W-1:0]   wdata;
    } st_t;

    st_t st_d, st_q;

    logic [2:0] pins_s, pins_p;
    logic sclk_s, cs_s, sdi_s, sclk_p, cs_p;
    logic rise, fall, cs_rise, oe, in_cid;
    logic [BYTE_W-1:0] byte_new;
    ctl_t ctl;

    spi_chain_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({spi_sclk, spi_cs_n, spi_sdi}),
        .dout(pins_s), .dout_prev(pins_p)
    );

    assign {sclk_s, cs_s, sdi_s} = pins_s;
    assign sclk_p  = pins_p[2];
    assign cs_p    = pins_p[1];
    assign rise    = !cs_s && sclk_s && !sclk_p;
    assign fall    = !cs_s && !sclk_s && sclk_p;
    assign cs_rise = cs_s && !cs_p;

    assign in_cid = !cs_s && (st_q.phase == PH_CTRL) &&
                    (st_q.bits >= CNT_W'(FLAG_BITS)) && (st_q.bits < CNT_W'(BYTE_W));

    spi_chain_fwd u_fwd (
        .clk(clk), .rst_n(rst_n), .sdi_raw(spi_sdi), .sdi_s(sdi_s),
        .rise(rise), .in_cid(in_cid), .sdi_thru(spi_sdi_thru)
    );

    assign oe = !cs_s && st_q.acc && st_q.rd &&
                (st_q.phase == PH_DAT0 || st_q.phase == PH_DAT1);
    assign byte_new = {st_q.sh, sdi_s};
    assign ctl = ctl_t'(byte_new);

    always_comb begin
        st_d        = st_q;
        st_d.reg_we = 1'b0;
        st_d.ram_we = 1'b0;
        st_d.fetch  = 1'b0;

        if (st_q.fetch) begin
            if (st_q.ram) st_d.rbuf = ram_rdata;
            else          st_d.tx   = {reg_rdata, {BYTE_W{1'b0}}};
        end

        if (cs_rise) begin
            if (st_q.bits == CNT_W'(BYTE_W)) st_d.phase = st_q.phase_nx;
            st_d.bits = '0;
        end else if (rise && st_q.bits != CNT_W'(BYTE_W)) begin
            st_d.sh   = byte_new[BYTE_W-2:0];
            st_d.bits = st_q.bits + 1'b1;
            if (st_q.bits == CNT_W'(BYTE_W - 1)) begin
                case (st_q.phase)
                    PH_CTRL: begin
                        st_d.bcast    = ctl.bcast;
                        st_d.rd       = ctl.rd;
                        st_d.ram      = ctl.ram;
                        st_d.acc      = ctl.bcast ? !ctl.rd : (ctl.cid_rev == '0);
                        st_d.phase_nx = PH_ADDR;
                    end
                    PH_ADDR: begin
                        st_d.addr     = byte_new;
                        st_d.phase_nx = PH_DAT0;
                        if (st_q.acc && st_q.rd) begin
                            st_d.fetch = 1'b1;
                            if (st_q.ram) st_d.tx = st_q.rbuf;
                        end
                    end
                    PH_DAT0: begin
                        if (st_q.ram) begin
                            st_d.hi       = byte_new;
                            st_d.phase_nx = PH_DAT1;
                        end else begin
                            st_d.phase_nx = PH_CTRL;
                            if (st_q.acc && !st_q.rd) begin
                                st_d.reg_we = 1'b1;
                                st_d.wdata  = {{BYTE_W{1'b0}}, byte_new};
                            end
                        end
                    end
                    default: begin
                        st_d.phase_nx = PH_CTRL;
                        if (st_q.acc && !st_q.rd) begin
                            st_d.ram_we = 1'b1;
                            st_d.wdata  = {st_q.hi, byte_new};
                        end
                    end
                endcase
            end
        end else if (fall && oe) begin
            st_d.tx = {st_q.tx[WORD_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign spi_sdo    = oe ? st_q.tx[WORD_W-1] : 1'b0;
    assign spi_sdo_oe = oe;
    assign mem_addr   = st_q.addr;
    assign wr_data    = st_q.wdata;
    assign reg_we     = st_q.reg_we;
    assign ram_we     = st_q.ram_we;

    AST_WE_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we || ram_we) |-> $past(rise)); // R3
    AST_REG_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we); // R3
    AST_RAM_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> !ram_we); // R4
    AST_BCAST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sdo_oe |-> !(st_q.bcast && st_q.rd)); // R8
    AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sdo_oe && $past(spi_sdo_oe) && !$past(fall) && !$past(st_q.fetch))
        |-> $stable(spi_sdo)); // R5
endmodule

// File: tb/tb_spi_chain_port.sv
`timescale 1ns/1ps
module tb_spi_chain_port;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, sclk, cs_n, sdi;
    logic sdo_a, oe_a, thru_a, reg_we_a, ram_we_a;
    logic sdo_b, oe_b, thru_b, reg_we_b, ram_we_b;
    logic [7:0]  addr_a, addr_b;
    logic [15:0] wd_a, wd_b;
    logic [7:0]  rrd_a, rrd_b;
    logic [15:0] mrd_a, mrd_b;

    assign rrd_a = addr_a ^ 8'hA5;
    assign rrd_b = addr_b ^ 8'hA5;
    assign mrd_a = {addr_a, ~addr_a};
    assign mrd_b = {addr_b, ~addr_b};

    spi_chain_port dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_sdi(sdi),
        .spi_sdo(sdo_a), .spi_sdo_oe(oe_a), .spi_sdi_thru(thru_a),
        .mem_addr(addr_a), .wr_data(wd_a), .reg_we(reg_we_a), .ram_we(ram_we_a),
        .reg_rdata(rrd_a), .ram_rdata(mrd_a));

    spi_chain_port dut_b (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_sdi(thru_a),
        .spi_sdo(sdo_b), .spi_sdo_oe(oe_b), .spi_sdi_thru(thru_b),
        .mem_addr(addr_b), .wr_data(wd_b), .reg_we(reg_we_b), .ram_we(ram_we_b),
        .reg_rdata(rrd_b), .ram_rdata(mrd_b));

    int checks = 0, errors = 0, clash = 0;
    bit done = 1'b0;
    logic [24:0] exp_a[$], exp_b[$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mk_ctrl(input logic bc, input logic rd, input logic ram,
                                           input logic [3:0] cid);
        return {bc, rd, ram, 1'b0, cid[0], cid[1], cid[2], cid[3]};
    endfunction

    // scoreboard monitors: write strobes popped against expected items
    always @(negedge clk) begin
        if (rst_n && (reg_we_a || ram_we_a)) begin
            if (exp_a.size() == 0) chk("R10 unexpected write ch0", {ram_we_a, addr_a, wd_a}, 32'hFFFF_FFFF);
            else chk("R3/R4 write ch0", {ram_we_a, addr_a, wd_a}, exp_a.pop_front());
        end
        if (rst_n && (reg_we_b || ram_we_b)) begin
            if (exp_b.size() == 0) chk("R10 unexpected write ch1", {ram_we_b, addr_b, wd_b}, 32'hFFFF_FFFF);
            else chk("R3/R4 write ch1", {ram_we_b, addr_b, wd_b}, exp_b.pop_front());
        end
    end

    task automatic xfer(input logic [7:0] b, input int nbits, output logic [7:0] got,
                        output logic [7:0] fw, output int oe_n);
        got = '0; fw = '0; oe_n = 0;
        cs_n = 1'b0; #60;
        for (int i = 7; i > 7 - nbits; i--) begin
            sdi = b[i]; #20;
            got[i] = oe_a ? sdo_a : (oe_b ? sdo_b : 1'b0);
            fw[i]  = thru_a;
            if (oe_a || oe_b) oe_n++;
            if (oe_a && oe_b) clash++;
            sclk = 1'b1; #40;
            sclk = 1'b0; #40;
        end
        cs_n = 1'b1; #60;
    endtask

    task automatic access(input logic [7:0] ctl, input logic [7:0] addr, input logic [15:0] data,
                          output logic [15:0] rdat, output int oe_tot, output logic [7:0] fwc);
        logic [7:0] g, f;
        int n;
        rdat = '0;
        xfer(ctl, 8, g, fwc, n); oe_tot = n;
        xfer(addr, 8, g, f, n);  oe_tot += n;
        if (ctl[5]) begin
            xfer(data[15:8], 8, g, f, n); oe_tot += n; rdat[15:8] = g;
            xfer(data[7:0], 8, g, f, n);  oe_tot += n; rdat[7:0]  = g;
        end else begin
            xfer(data[7:0], 8, g, f, n);  oe_tot += n; rdat[7:0]  = g;
        end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        logic [7:0]  fw, g, f;
        int oe_n, n;
        rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; sdi = 1'b0;
        repeat (10) @(posedge clk);
        rst_n = 1'b1;
        repeat (10) @(posedge clk);
        #1;
        chk("R7 reset oe ch0", oe_a, 0);
        chk("R7 reset oe ch1", oe_b, 0);
        sdi = 1'b1; #1;
        chk("R2 idle pass-through", thru_a, 1);
        sdi = 1'b0; #20;

        // register write to channel 0, identifier wraps 0 -> 15
        exp_a.push_back({1'b0, 8'h21, 16'h005C});
        access(mk_ctrl(0,0,0,4'd0), 8'h21, 16'h005C, rd, oe_n, fw);
        chk("R2 forward cid0->15", fw, mk_ctrl(0,0,0,4'd15));
        chk("R7 no drive on write", oe_n, 0);

        // register write to channel 1 via decrement
        exp_b.push_back({1'b0, 8'h33, 16'h0081});
        access(mk_ctrl(0,0,0,4'd1), 8'h33, 16'h0081, rd, oe_n, fw);
        chk("R2 forward cid1->0", fw, mk_ctrl(0,0,0,4'd0));

        // RAM write to channel 0
        exp_a.push_back({1'b1, 8'h07, 16'hBEEF});
        access(mk_ctrl(0,0,1,4'd0), 8'h07, 16'hBEEF, rd, oe_n, fw);
        chk("R4 forward flags ram", fw, mk_ctrl(0,0,1,4'd15));

        // broadcast register write, identifier 5 -> 4
        exp_a.push_back({1'b0, 8'h10, 16'h0066});
        exp_b.push_back({1'b0, 8'h10, 16'h0066});
        access(mk_ctrl(1,0,0,4'd5), 8'h10, 16'h0066, rd, oe_n, fw);
        chk("R1 R2 broadcast forward 5->4", fw, mk_ctrl(1,0,0,4'd4));

        // register reads
        access(mk_ctrl(0,1,0,4'd0), 8'h40, 16'h0000, rd, oe_n, fw);
        chk("R5 reg read ch0", rd, 16'h00E5);
        chk("R7 drive during reg read", oe_n, 8);
        access(mk_ctrl(0,1,0,4'd1), 8'h41, 16'h0000, rd, oe_n, fw);
        chk("R1 R5 reg read ch1", rd, 16'h00E4);

        // RAM read pipeline
        access(mk_ctrl(0,1,1,4'd0), 8'h12, 16'h0000, rd, oe_n, fw);
        chk("R6 first ram read buffer zero", rd, 16'h0000);
        chk("R7 drive during ram read", oe_n, 16);
        access(mk_ctrl(0,1,1,4'd0), 8'h34, 16'h0000, rd, oe_n, fw);
        chk("R6 ram read one behind", rd, 16'h12ED);

        // broadcast read ignored, buffer untouched
        access(mk_ctrl(1,1,1,4'd0), 8'h55, 16'h0000, rd, oe_n, fw);
        chk("R8 broadcast read no drive", oe_n, 0);
        access(mk_ctrl(0,1,1,4'd0), 8'h56, 16'h0000, rd, oe_n, fw);
        chk("R8 R6 buffer kept over broadcast read", rd, 16'h34CB);

        // identifier 8: nobody acts, borrow ripples 8 -> 7
        access(mk_ctrl(0,0,0,4'd8), 8'h77, 16'h0011, rd, oe_n, fw);
        chk("R2 forward cid8->7", fw, mk_ctrl(0,0,0,4'd7));

        // partial byte in the data slot
        exp_a.push_back({1'b0, 8'h2A, 16'h003C});
        xfer(mk_ctrl(0,0,0,4'd0), 8, g, f, n);
        xfer(8'h2A, 8, g, f, n);
        xfer(8'hFF, 3, g, f, n);
        xfer(8'h3C, 8, g, f, n);

        // partial byte before a control byte
        xfer(8'hE0, 5, g, f, n);
        access(mk_ctrl(0,1,0,4'd0), 8'h40, 16'h0000, rd, oe_n, fw);
        chk("R9 partial before control", rd, 16'h00E5);

        repeat (20) @(posedge clk);
        #1;
        chk("R10 all expected writes ch0", exp_a.size(), 0);
        chk("R10 all expected writes ch1", exp_b.size(), 0);
        chk("R7 no SDO clash", clash, 0);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule